// File: doc/BRIEF.md
# Program Sequencer for a 4-bit Microcontroller

This unit supplies the 12-bit instruction fetch address of a small 4-bit microcontroller and executes its control-flow instructions. The address is held as a 6-bit page and a 6-bit in-page offset. Each clock the unit receives the byte stored at the current address. It then either steps to the next byte inside the same page or loads a new address from a jump, a call or a return. A two-entry return stack holds the addresses that calls save. A skip mechanism turns the next instruction into a no-operation. The unit also drives an interrupt-master-enable flag, which one of the return forms sets.

Skips come from two places. One return form requests a skip itself, and the neighbouring units can request one through an external pin, for example after a compare. Two-word instructions (long jump, long call) take two cycles. The first cycle captures the opcode and the second consumes the operand byte. A skipped two-word instruction also takes two cycles, so skipping never changes the timing of the rest of the program.

Top module: `prog_seq`

## Requirements
- R1: While rst is high and on the first cycle after it falls, addr_o is 0x000 and ime_o is 0. Both stack entries are cleared to 0x000.
- R2: A byte outside the control-flow ranges below is one word long. It advances the offset addr_o[5:0] by one modulo 64 and leaves the page addr_o[11:6] unchanged.
- R3: A byte in 0x80–0xBF loads its low six bits into the offset in the next cycle and keeps the page.
- R4: A byte in 0xE0–0xEF is a two-word jump. In its first cycle the address only steps (R2). In the second cycle the address becomes {first[3:0], operand[7:0]}, so the page is bits 11–6 and the offset is bits 5–0.
- R5: A byte in 0xF0–0xFF is a two-word call with the target built as in R4. It pushes the stepped address of the operand byte, which is the address of the following instruction.
- R6: A byte in 0xC0–0xDF is a one-word table call. It pushes the stepped address, sets the page to 0x01 and sets the offset to {byte[4:0], 0}.
- R7: Byte 0x7D pops the top stack entry into the address.
- R8: Byte 0x7E pops like R7 and then skips the instruction at the popped address.
- R9: Byte 0x7F pops like R7 and sets ime_o to 1 in the same cycle the address changes. ime_o then stays 1 until reset.
- R10: A skipped one-word instruction takes one cycle and only steps the address. It causes no load, push, pop or change to ime_o.
- R11: A skipped two-word instruction (first byte 0xE0–0xFF) takes two cycles. Each cycle only steps the address, and the operand byte is not used.
- R12: If skip_i is high in the last cycle of an executed instruction, the next instruction is skipped. skip_i is ignored in the first cycle of a two-word instruction and in skipped cycles.
- R13: The stack is two entries deep. A third push drops the oldest entry. A pop moves the second entry up and keeps it in place, so popping an empty stack returns the last value popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 8 | Program byte stored at addr_o |
| skip_i | input | 1 | External request to skip the next instruction |
| addr_o | output | 12 | Fetch address, page in bits 11–6 and offset in bits 5–0 |
| ime_o | output | 1 | Interrupt-master-enable flag |

## Verification
Every result of this block appears on a registered output one clock edge after the cycle that consumes the byte, and nowhere else. A jump, call or return shows on addr_o after the edge that ends its last word, so a two-word instruction shows after the second edge. ime_o rises on the same edge as the address loaded by its return. The bench sets skip_i and steps its own instruction model at the falling edge, using the byte the model expects at the current address. It compares both outputs at the next falling edge, which is exactly one register stage later. Every step is therefore checked in the cycle its result is due, including skips, two-word operand cycles and stack wrap and repeat.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    K_STEP,
    K_JMP,
    K_TCALL,
    K_LONG,
    K_RET,
    K_RETSKIP,
    K_RETIE
  } op_kind_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [7:0] op,
  output op_kind_e   kind,
  output logic       two_word
);
  always_comb begin
    two_word = (op[7:5] == 3'b111);
    if (op[7:6] == 2'b10)       kind = K_JMP;
    else if (op[7:5] == 3'b110) kind = K_TCALL;
    else if (two_word)          kind = K_LONG;
    else if (op == 8'h7D)       kind = K_RET;
    else if (op == 8'h7E)       kind = K_RETSKIP;
    else if (op == 8'h7F)       kind = K_RETIE;
    else                        kind = K_STEP;
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int W     = 12,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  logic [W-1:0] ent [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[gi] <= '0;
      end else if (push) begin
        if (gi == 0) ent[gi] <= din;
        else         ent[gi] <= ent[(gi == 0) ? 0 : gi-1];
      end else if (pop && gi < DEPTH-1) begin
        ent[gi] <= ent[(gi < DEPTH-1) ? gi+1 : gi];
      end
    end
  end

  assign top = ent[0];

  // R13: a push lands on top of the stack
  p_push_top_r13: assert property (@(posedge clk) disable iff (rst)
    push |=> top == $past(din));
  // R13: a pop exposes the former second entry
  p_pop_shift_r13: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> top == $past(ent[1]));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import seq_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int OFF_W     = 6,
  parameter int STK_DEPTH = 2,
  parameter int TBL_PAGE  = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [7:0]                instr_i,
  input  logic                      skip_i,
  output logic [PAGE_W+OFF_W-1:0]   addr_o,
  output logic                      ime_o
);
  localparam int ADDR_W = PAGE_W + OFF_W;

  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [4:0]        op_q;
  logic              inop_q, inop_d;
  logic              skip_q, skip_d;
  logic              ime_q, ime_set;
  logic              push, pop;
  logic [ADDR_W-1:0] pc_inc, stk_top, long_tgt;
  op_kind_e          kind;
  logic              two_word;
  logic              exec_first;

  seq_decode u_dec (
    .op       (instr_i),
    .kind     (kind),
    .two_word (two_word)
  );

  ret_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .din  (pc_inc),
    .top  (stk_top)
  );

  assign pc_inc     = {page_q, off_q + OFF_W'(1)};
  assign long_tgt   = ADDR_W'({op_q[3:0], instr_i});
  assign exec_first = !inop_q && !skip_q;

  always_comb begin
    {page_d, off_d} = pc_inc;
    inop_d  = 1'b0;
    skip_d  = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    ime_set = 1'b0;
    if (inop_q) begin
      if (!skip_q) begin
        {page_d, off_d} = long_tgt;
        push   = op_q[4];
        skip_d = skip_i;
      end
    end else if (skip_q) begin
      if (two_word) begin
        inop_d = 1'b1;
        skip_d = 1'b1;
      end
    end else begin
      skip_d = skip_i;
      case (kind)
        K_JMP:   off_d = instr_i[OFF_W-1:0];
        K_TCALL: begin
          push   = 1'b1;
          page_d = PAGE_W'(TBL_PAGE);
          off_d  = OFF_W'({instr_i[4:0], 1'b0});
        end
        K_LONG: begin
          inop_d = 1'b1;
          skip_d = 1'b0;
        end
        K_RET: begin
          pop = 1'b1;
          {page_d, off_d} = stk_top;
        end
        K_RETSKIP: begin
          pop = 1'b1;
          {page_d, off_d} = stk_top;
          skip_d = 1'b1;
        end
        K_RETIE: begin
          pop = 1'b1;
          {page_d, off_d} = stk_top;
          ime_set = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
      op_q   <= '0;
      inop_q <= 1'b0;
      skip_q <= 1'b0;
      ime_q  <= 1'b0;
    end else begin
      page_q <= page_d;
      off_q  <= off_d;
      inop_q <= inop_d;
      skip_q <= skip_d;
      if (inop_d && !inop_q) op_q <= instr_i[4:0];
      if (ime_set) ime_q <= 1'b1;
    end
  end

  assign addr_o = {page_q, off_q};
  assign ime_o  = ime_q;

  // R1: reset leaves the address at zero and the flag clear
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && !ime_o));
  // R3: short jump keeps the page and takes the low opcode bits
  p_jmp_page_r3: assert property (@(posedge clk) disable iff (rst)
    (exec_first && kind == K_JMP) |=>
      (addr_o[ADDR_W-1:OFF_W] == $past(addr_o[ADDR_W-1:OFF_W]) &&
       addr_o[OFF_W-1:0] == $past(instr_i[OFF_W-1:0])));
  // R4: the operand cycle lasts exactly one cycle
  p_operand_once_r4: assert property (@(posedge clk) disable iff (rst)
    inop_q |=> !inop_q);
  // R6: table call lands on the fixed page at an even offset
  p_tcall_tgt_r6: assert property (@(posedge clk) disable iff (rst)
    (exec_first && kind == K_TCALL) |=>
      (addr_o[ADDR_W-1:OFF_W] == PAGE_W'(TBL_PAGE) && !addr_o[0]));
  // R9: the flag only rises after the enabling return
  p_ime_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ime_o) |-> $past(exec_first && kind == K_RETIE));
  // R10: a skipped one-word byte only steps inside the page
  p_skip_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!inop_q && skip_q && !two_word) |=>
      (addr_o[ADDR_W-1:OFF_W] == $past(addr_o[ADDR_W-1:OFF_W]) &&
       addr_o[OFF_W-1:0] == $past(addr_o[OFF_W-1:0]) + OFF_W'(1) &&
       !skip_q));
endmodule

// File: tb/test_prog_seq.sv
module test_prog_seq;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        skip_i = 1'b0;
  logic [7:0]  instr_i;
  logic [11:0] addr_o;
  logic        ime_o;
  logic [7:0]  rom [4096];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [11:0] m_pc, m_stk0, m_stk1;
  logic [3:0]  m_opn;
  logic        m_call, m_inop, m_skip, m_ime, m_ext;
  int          m_cnt;
  string       m_tag;
  int unsigned rs;

  always #(CYC/2) clk = ~clk;

  assign instr_i = rom[addr_o];

  prog_seq i_prog_seq (
    .clk     (clk),
    .rst     (rst),
    .instr_i (instr_i),
    .skip_i  (skip_i),
    .addr_o  (addr_o),
    .ime_o   (ime_o)
  );

  function automatic int unsigned nxt(int unsigned x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [11:0] stepa(logic [11:0] a);
    return {a[11:6], a[5:0] + 6'd1};
  endfunction

  task automatic check(string tag, logic [11:0] a_exp, logic i_exp);
    checks++;
    if (addr_o !== a_exp || ime_o !== i_exp) begin
      errors++;
      $display("FAIL %s addr=%h ime=%b expected addr=%h ime=%b",
               tag, addr_o, ime_o, a_exp, i_exp);
      m_pc  = addr_o;
      m_ime = ime_o;
    end
  endtask

  task automatic push_m(logic [11:0] v);
    if (m_cnt == 2) m_tag = {m_tag, "+R13"};
    m_stk1 = m_stk0;
    m_stk0 = v;
    if (m_cnt < 2) m_cnt++;
  endtask

  task automatic pop_m();
    if (m_cnt == 0) m_tag = {m_tag, "+R13"};
    m_pc   = m_stk0;
    m_stk0 = m_stk1;
    if (m_cnt > 0) m_cnt--;
  endtask

  // one instruction cycle of the reference behaviour
  task automatic model_step(logic [7:0] b, logic s);
    if (m_inop) begin
      m_inop = 1'b0;
      if (m_skip) begin
        m_tag  = m_ext ? "R12 skipped two-word" : "R11 skipped two-word";
        m_pc   = stepa(m_pc);
        m_skip = 1'b0;
      end else begin
        m_tag = m_call ? "R5 long call" : "R4 long jump";
        if (m_call) push_m(stepa(m_pc));
        m_pc   = {m_opn, b};
        m_skip = s;
        m_ext  = s;
      end
    end else if (m_skip) begin
      m_pc = stepa(m_pc);
      if (b >= 8'hE0) begin
        m_inop = 1'b1;
        m_tag  = m_ext ? "R12 skip first word" : "R11 skip first word";
      end else begin
        m_skip = 1'b0;
        m_tag  = m_ext ? "R12 skipped one-word" : "R10 skipped one-word";
      end
    end else begin
      m_skip = s;
      m_ext  = s;
      if (b >= 8'h80 && b <= 8'hBF) begin
        m_tag = "R3 short jump";
        m_pc  = {m_pc[11:6], b[5:0]};
      end else if (b >= 8'hC0 && b <= 8'hDF) begin
        m_tag = "R6 table call";
        push_m(stepa(m_pc));
        m_pc = {6'd1, b[4:0], 1'b0};
      end else if (b >= 8'hE0) begin
        m_tag  = "R4 first word";
        m_opn  = b[3:0];
        m_call = b[4];
        m_inop = 1'b1;
        m_pc   = stepa(m_pc);
        m_skip = 1'b0;
        m_ext  = 1'b0;
      end else if (b == 8'h7D) begin
        m_tag = "R7 return";
        pop_m();
      end else if (b == 8'h7E) begin
        m_tag = "R8 return and skip";
        pop_m();
        m_skip = 1'b1;
        m_ext  = 1'b0;
      end else if (b == 8'h7F) begin
        m_tag = "R9 return and enable";
        pop_m();
        m_ime = 1'b1;
      end else begin
        m_tag = "R2 step";
        m_pc  = stepa(m_pc);
      end
    end
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rs = 32'h1234_5678;
    for (int seg = 0; seg < 40; seg++) begin
      // fresh program: returns made more frequent than uniform bytes
      for (int a = 0; a < 4096; a++) begin
        rs = nxt(rs);
        if (rs[2:0] == 3'd0) rom[a] = 8'h7D + 8'(rs[9:3] % 3);
        else                 rom[a] = rs[15:8];
      end
      rst    = 1'b1;
      skip_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 during reset", 12'h000, 1'b0);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pc = '0; m_stk0 = '0; m_stk1 = '0; m_opn = '0;
      m_call = 0; m_inop = 0; m_skip = 0; m_ime = 0; m_ext = 0; m_cnt = 0;
      check("R1 after reset", 12'h000, 1'b0);
      for (int i = 0; i < 500; i++) begin
        logic s;
        rs = nxt(rs);
        s = (seg % 4 == 0) ? 1'b0 : (rs[3:0] < 4'd3);
        skip_i = s;
        model_step(rom[m_pc], s);
        @(negedge clk);
        check(m_tag, m_pc, m_ime);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule